// File: doc/BRIEF.md
# Serial Converter Output Emulator

This block stands in for the serial output side of a 12-bit successive-approximation converter. Test logic presents a parallel sample word, and a host drives a chip-select line and a serial clock. The emulator then returns data the way the real converter would. Each frame latches one sample word. That word is returned during the following frame, so the output lags by one frame. The data bit steps on serial clock falling edges, most significant bit first. The word is framed by leading zeros and trailing zeros.

The host lines are sampled on the rising edges of the system clock `clk`. They must therefore be synchronous to it, or at least slow enough that the system clock oversamples them. Every output is registered. An output reacts one `clk` cycle after the first rising edge that samples the host change.

A frame ends when chip select rises. If that happens before fourteen counted falling edges, the frame's sample is discarded and a wrap-around abort counter steps. The data pin carries an output-enable that is low, with data held at zero, while the device is deselected.

Top module: `adc_emu_serial_out`

## Requirements
- R1: While chip select `cs_n` is sampled high, `sdo_oe` is 0 and `sdo` is 0 from the next cycle on.
- R2: One cycle after `cs_n` is first sampled low, `sdo_oe` is 1 and `sdo` is 0. This is the first leading zero, and it appears before any serial clock edge.
- R3: The number of leading zeros follows `sclk` as sampled in the same cycle that `cs_n` is first seen low: 2 if `sclk` is 1, and 1 if `sclk` is 0.
- R4: A counted falling edge advances `sdo` by one bit, one cycle later. A counted falling edge is `sclk` going from 1 to 0 between consecutive samples while `cs_n` was low in both samples. Without a counted falling edge, `sdo` holds.
- R5: After the least significant bit, every further counted falling edge in the frame gives `sdo` = 0.
- R6: `sample_in` is latched in the cycle `cs_n` is first sampled low. It is shifted out, bit 11 first and bit 0 last, in the next frame that follows a complete frame. Later changes to `sample_in` within the frame have no effect.
- R7: A frame is complete if at least 14 falling edges were counted before `cs_n` is sampled high. A complete frame commits its latched sample as the next output word. An incomplete frame leaves the output word unchanged and increments `abort_count` by 1, modulo 2^ABORT_W. `abort_count` changes at no other time.
- R8: After reset, `abort_count` is 0 and the first frame shifts out an all-zero word.
- R9: A `sclk` falling edge sampled in the same cycle as `cs_n` rising is not counted. A `sclk` falling edge sampled in the same cycle as `cs_n` falling is not counted either, and in that case it yields one leading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_in | input | SAMPLE_W (12) | Parallel word taken as the current conversion result |
| cs_n | input | 1 | Host chip select, active low, frames a transfer |
| sclk | input | 1 | Host serial clock |
| sdo | output | 1 | Serial data bit, 0 while output-enable is low |
| sdo_oe | output | 1 | Output enable for the serial data pin |
| abort_count | output | ABORT_W (8) | Count of frames ended before 14 falling edges |

## Verification
Two boundary events can collide with a serial clock falling edge in the same system-clock cycle. The first is the end of a frame: the bench raises `cs_n` and drops `sclk` together after only 13 counted edges. The design must treat that as an aborted frame, so `abort_count` steps and the next frame still returns the older word. The second is the start of a frame: the bench drops `cs_n` and `sclk` together. Only one leading zero may appear, and that edge must not shift the word. A behavioural reference model judges both collisions every cycle, alongside direct checks of the bits captured after each edge.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Most leading zeros a frame can carry (serial clock idling high).
  localparam int unsigned LEAD_MAX = 2;

  // Host line events seen in one system-clock cycle.
  typedef struct packed {
    logic cs_fall;    // chip select first seen low
    logic cs_rise;    // chip select first seen high
    logic sclk_fall;  // counted serial clock falling edge
    logic sclk_lvl;   // current serial clock level
  } host_evt_t;

endpackage

// File: rtl/adc_emu_rst_sync.sv
module adc_emu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/adc_emu_edges.sv
module adc_emu_edges
  import adc_emu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      cs_n,
  input  logic      sclk,
  output host_evt_t evt
);

  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  always_comb begin
    evt.cs_fall   = cs_q & ~cs_n;
    evt.cs_rise   = ~cs_q & cs_n;
    // Count only inside an open frame: the select must be low in both samples.
    evt.sclk_fall = sclk_q & ~sclk & ~cs_q & ~cs_n;
    evt.sclk_lvl  = sclk;
  end

endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame
  import adc_emu_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned MIN_FALLS = 14,
  parameter int unsigned ABORT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  host_evt_t           evt,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [SAMPLE_W-1:0] tx_word,
  output logic [ABORT_W-1:0]  abort_count
);

  localparam int unsigned FC_W = $clog2(MIN_FALLS + 1);
  localparam logic [FC_W-1:0] FULL_CNT = FC_W'(MIN_FALLS);

  logic [FC_W-1:0]     fall_q, fall_d;
  logic [SAMPLE_W-1:0] conv_q, conv_d;
  logic [SAMPLE_W-1:0] word_q, word_d;
  logic [ABORT_W-1:0]  abort_q, abort_d;
  logic                full_frame;

  assign full_frame = (fall_q == FULL_CNT);

  always_comb begin
    fall_d  = fall_q;
    conv_d  = conv_q;
    word_d  = word_q;
    abort_d = abort_q;
    if (evt.cs_fall) begin
      conv_d = sample_in;
      fall_d = '0;
    end else if (evt.sclk_fall && !full_frame) begin
      fall_d = fall_q + 1'b1;
    end
    if (evt.cs_rise) begin
      if (full_frame) begin
        word_d = conv_q;
      end else begin
        abort_d = abort_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q  <= '0;
      conv_q  <= '0;
      word_q  <= '0;
      abort_q <= '0;
    end else begin
      fall_q  <= fall_d;
      conv_q  <= conv_d;
      word_q  <= word_d;
      abort_q <= abort_d;
    end
  end

  assign tx_word     = word_q;
  assign abort_count = abort_q;

endmodule

// File: rtl/adc_emu_shifter.sv
module adc_emu_shifter
  import adc_emu_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  host_evt_t           evt,
  input  logic [SAMPLE_W-1:0] tx_word,
  output logic                sdo,
  output logic                sdo_oe
);

  localparam int unsigned SH_W = SAMPLE_W + LEAD_MAX;

  logic [SH_W-1:0] sh_q, sh_d;
  logic [SH_W-1:0] frame_img;
  logic            oe_q, oe_d;

  // Two leading zeros when the clock idles high, otherwise one (shift by one).
  always_comb begin
    frame_img = {{LEAD_MAX{1'b0}}, tx_word};
    if (!evt.sclk_lvl) begin
      frame_img = frame_img << 1;
    end
  end

  always_comb begin
    sh_d = sh_q;
    oe_d = oe_q;
    if (evt.cs_fall) begin
      oe_d = 1'b1;
      sh_d = frame_img;
    end else if (evt.cs_rise) begin
      oe_d = 1'b0;
      sh_d = '0;
    end else if (evt.sclk_fall) begin
      sh_d = {sh_q[SH_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign sdo    = sh_q[SH_W-1] & oe_q;
  assign sdo_oe = oe_q;

endmodule

// File: rtl/adc_emu_serial_out.sv
module adc_emu_serial_out
  import adc_emu_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned MIN_FALLS = 14,
  parameter int unsigned ABORT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                cs_n,
  input  logic                sclk,
  output logic                sdo,
  output logic                sdo_oe,
  output logic [ABORT_W-1:0]  abort_count
);

  logic                rst_sync_n;
  host_evt_t           evt;
  logic [SAMPLE_W-1:0] tx_word;

  adc_emu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_emu_edges u_edges (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .evt    (evt)
  );

  adc_emu_frame #(
    .SAMPLE_W  (SAMPLE_W),
    .MIN_FALLS (MIN_FALLS),
    .ABORT_W   (ABORT_W)
  ) u_frame (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .evt         (evt),
    .sample_in   (sample_in),
    .tx_word     (tx_word),
    .abort_count (abort_count)
  );

  adc_emu_shifter #(
    .SAMPLE_W (SAMPLE_W)
  ) u_shift (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .evt     (evt),
    .tx_word (tx_word),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

endmodule

// File: rtl/adc_emu_serial_out_chk.sv
module adc_emu_serial_out_chk #(
  parameter int unsigned ABORT_W = 8
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               cs_n,
  input logic               sclk,
  input logic               sdo,
  input logic               sdo_oe,
  input logic [ABORT_W-1:0] abort_count
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    cs_n |=> (!sdo_oe && !sdo));

  assert_data_gated_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    sdo |-> sdo_oe);

  assert_first_zero_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(cs_n) |=> (sdo_oe && !sdo));

  assert_hold_without_edge_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cs_n && !$fell(cs_n) && !$fell(sclk)) |=> ($stable(sdo) && sdo_oe));

  assert_abort_at_end_only_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !$rose(cs_n) |=> $stable(abort_count));

endmodule

bind adc_emu_serial_out adc_emu_serial_out_chk #(
  .ABORT_W (ABORT_W)
) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .sdo         (sdo),
  .sdo_oe      (sdo_oe),
  .abort_count (abort_count)
);

// File: tb/adc_emu_serial_out_test.sv
`timescale 1ns/1ps
module adc_emu_serial_out_test;

  logic        clk;
  logic        rst_n;
  logic [11:0] sample_in;
  logic        cs_n;
  logic        sclk;
  logic        sdo;
  logic        sdo_oe;
  logic [7:0]  abort_count;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  adc_emu_serial_out uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_in   (sample_in),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .abort_count (abort_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  bit        m_cs, m_sclk, m_oe;
  bit        m_q[$];
  int        m_falls;
  logic [11:0] m_word, m_conv;
  logic [7:0]  m_abort;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 1; m_sclk = 0; m_oe = 0; m_q.delete(); m_falls = 0;
      m_word = 0; m_conv = 0; m_abort = 0;
    end else begin
      if (m_cs && !cs_n) begin
        m_q.delete();
        m_q.push_back(1'b0);
        if (sclk) m_q.push_back(1'b0);
        for (int i = 11; i >= 0; i--) m_q.push_back(m_word[i]);
        m_conv = sample_in; m_falls = 0; m_oe = 1;
      end else if (!m_cs && cs_n) begin
        if (m_falls >= 14) m_word = m_conv;
        else m_abort = m_abort + 8'd1;
        m_q.delete(); m_oe = 0;
      end else if (!cs_n && !m_cs && m_sclk && !sclk) begin
        m_falls++;
        if (m_q.size() > 0) void'(m_q.pop_front());
      end
      m_cs = cs_n; m_sclk = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_sdo;
      e_sdo = (m_oe && m_q.size() > 1) ? m_q[1] : 1'b0;
      if (m_oe && m_q.size() > 0) e_sdo = m_q[0];
      check(sdo_oe === m_oe, m_oe ? "R2 model enable" : "R1 model enable", {15'd0, sdo_oe}, {15'd0, m_oe});
      check(sdo === e_sdo, m_oe ? "R4 model data" : "R1 model data", {15'd0, sdo}, {15'd0, e_sdo});
      check(abort_count === m_abort, "R7 model abort count", {8'd0, abort_count}, {8'd0, m_abort});
    end
  end

  // Independent frame bookkeeping for the direct checks.
  logic [11:0] exp_word;
  logic [7:0]  exp_abort;

  function automatic bit seq_bit(input logic [11:0] w, input int lead, input int k);
    if (k < lead) return 1'b0;
    if (k < lead + 12) return w[11 - (k - lead)];
    return 1'b0;
  endfunction

  task automatic run_frame(input bit idle_hi, input bit start_fall, input int nfalls,
                           input bit end_fall, input logic [11:0] smp);
    logic [11:0] prev;
    int lead;
    bit eb;
    prev = exp_word;
    cs_n = 1'b1;
    sclk = idle_hi | start_fall;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    sample_in = smp;
    if (start_fall) sclk = 1'b0;
    lead = (idle_hi && !start_fall) ? 2 : 1;
    @(negedge clk);
    check(sdo_oe === 1'b1 && sdo === 1'b0, "R2 first leading zero", {14'd0, sdo_oe, sdo}, 16'h2);
    sample_in = ~smp;  // R6: too late to matter
    for (int k = 1; k <= nfalls; k++) begin
      if (sclk == 1'b0) begin
        sclk = 1'b1;
        @(negedge clk);
      end
      sclk = 1'b0;
      @(negedge clk);
      eb = seq_bit(prev, lead, k);
      if (k < lead)
        check(sdo === eb, "R3 leading zero", {15'd0, sdo}, {15'd0, eb});
      else if (k < lead + 12)
        check(sdo === eb, "R6 previous-frame word bit", {15'd0, sdo}, {15'd0, eb});
      else
        check(sdo === eb, "R5 trailing zero", {15'd0, sdo}, {15'd0, eb});
    end
    if (end_fall) begin
      sclk = 1'b1;
      @(negedge clk);
      cs_n = 1'b1;
      sclk = 1'b0;
    end else begin
      if (idle_hi) begin
        sclk = 1'b1;
        @(negedge clk);
      end
      cs_n = 1'b1;
    end
    @(negedge clk);
    if (nfalls >= 14) exp_word = smp;
    else exp_abort = exp_abort + 8'd1;
    check(abort_count === exp_abort, end_fall ? "R9 edge at frame end not counted" : "R7 abort count",
          {8'd0, abort_count}, {8'd0, exp_abort});
    check(sdo_oe === 1'b0 && sdo === 1'b0, "R1 released after frame", {14'd0, sdo_oe, sdo}, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sample_in = 12'h000;
    exp_word = 12'h000; exp_abort = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdo_oe === 1'b0 && sdo === 1'b0, "R1 idle after reset", {14'd0, sdo_oe, sdo}, 16'h0);
    check(abort_count === 8'd0, "R8 abort count after reset", {8'd0, abort_count}, 16'h0);

    run_frame(1, 0, 14, 0, 12'hA5C);  // R8: shifts out zero word, two leading zeros
    run_frame(0, 0, 16, 0, 12'h3F1);  // R3 one lead, R5 trailing zeros
    run_frame(1, 0, 10, 0, 12'h777);  // R7 aborted frame
    run_frame(0, 0, 14, 0, 12'h0F0);  // R7 still returns 3F1
    run_frame(0, 0, 13, 1, 12'hFFF);  // R9 coincident end edge -> abort
    run_frame(1, 1, 15, 0, 12'h800);  // R9 coincident start edge, one lead
    run_frame(1, 0, 14, 0, 12'h001);
    run_frame(0, 0, 14, 0, 12'hBEE);  // R6 returns 001
    run_frame(1, 0, 16, 0, 12'h000);  // returns BEE

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule